// File: doc/BRIEF.md
# Interrupt Translation Fault Recorder

This block sits beside an interrupt-remapping engine and keeps a log of the translation faults that engine detects. Each fault arrives as a one-cycle strobe carrying a reason code, the requester's source ID and the interrupt-table index. A fault with a supported reason is written into the next slot of a small circular set of 128-bit recording slots. The block then updates a status register that tracks a pending primary fault and an overflow condition. When software needs to be told about the fault, the block issues one message-signalled interrupt write, built from a programmable address register and a programmable data register.

Software reads the status, control and slot contents through a 32-bit register port, and clears them the same way. It frees slots one at a time, clears the overflow flag by writing 1 to it, and masks or unmasks the event. A new event is only signalled when no earlier fault status was still set. An event raised while the mask was set is held as a pending flag and is sent when software unmasks. After the slots overflow, later faults are dropped until software clears the overflow flag.

Register map (byte offsets; an access whose two low address bits are not zero selects nothing): 0x00 status, 0x04 event control, 0x08 message address, 0x0C message data, 0x10 + 16*slot + 4*dword for the recording slots.

Top module: `fault_log_ctrl`

## Requirements
- R1: After reset the status register reads 0, the control register reads 0x8000_0000 (masked, nothing pending), the message address and data registers read 0, every slot reads 0, and msg_valid and unsup_err are low.
- R2: A supported fault that finds overflow clear and the slot at the allocation pointer free fills that slot. Dword 3 then reads bit 31 = 1 and bits 7:0 = reason, dword 2 bits 15:0 = source ID, dword 1 bits 31:16 = interrupt index (record bit 48 upward), and dword 0 = 0. Status bits 15:8 hold that slot's number, and the pointer advances, wrapping after the last slot.
- R3: Status bit 1 (primary pending) reads 1 exactly when at least one slot has its valid bit set. Writing status does not clear it.
- R4: A supported fault that finds the slot at the pointer already valid sets status bit 0 (overflow) and records nothing. While overflow is set, supported faults leave the slots, the pointer and the status unchanged.
- R5: A fault report made while no status bit (bits 1:0) was set issues one message when control bit 31 (mask) is 0, and leaves control bit 30 (pending) at 0. When the mask is 1, the report sets pending and issues no message.
- R6: A fault report made while a status bit was already set issues no message and leaves pending unchanged.
- R7: Writing control with bit 31 = 0 while pending is set clears pending and issues the message. Control bit 30 cannot be written by software.
- R8: Writing status with bit 0 = 1 clears overflow. If afterwards neither status bit is set, pending is cleared.
- R9: Writing a slot's dword 3 with bit 31 = 1 clears that slot's valid bit. If no slot remains valid, primary pending is cleared, and pending is also cleared when overflow is not set.
- R10: A message raises msg_valid in the cycle after the event, with msg_addr and msg_data taken from the address and data registers. It stays high with stable contents until msg_ready is seen, and drops after acceptance unless a new message is loaded.
- R11: When a register write and a fault arrive on the same clock edge, the write takes effect first and the fault sees its result. For example, freeing the slot at the pointer in the same cycle lets the fault be recorded there instead of overflowing.
- R12: A fault whose reason lies outside the parameter range REASON_LO..REASON_HI (default 0x20..0x26) sets the sticky output unsup_err, which only reset clears, and changes no slot or status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_valid | input | 1 | Fault strobe |
| flt_reason | input | 8 | Fault reason code |
| flt_source | input | SRC_W | Requester source ID |
| flt_index | input | IDX_W | Interrupt-table index of the faulting request |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte address (reads and writes) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| msg_valid | output | 1 | Interrupt message valid |
| msg_addr | output | 32 | Interrupt message address |
| msg_data | output | 32 | Interrupt message data |
| msg_ready | input | 1 | Interrupt message accepted |
| unsup_err | output | 1 | Sticky unsupported-reason flag |

## Verification
The bench builds the block with four recording slots in place of the default single slot, so the allocation pointer really wraps. With four slots, a run of faults walks the pointer across every slot, the fifth fault overflows into a still-valid slot, and one slot can be freed while others stay valid, which shows primary pending being recomputed rather than simply cleared. Four slots also allow a slot free and a new fault to land on the same edge at the pointer. A seeded random phase then mixes faults, slot frees, status clears and mask changes, and tracks the count of messages.

// File: rtl/fault_log_pkg.sv
package fault_log_pkg;

   // register byte offsets
   localparam int OFF_STATUS   = 'h00;
   localparam int OFF_CTRL     = 'h04;
   localparam int OFF_MADDR    = 'h08;
   localparam int OFF_MDATA    = 'h0C;
   localparam int OFF_REC_BASE = 'h10;
   localparam int REC_BYTES    = 16;

   // bit positions
   localparam int ST_OVF     = 0;
   localparam int ST_PEND    = 1;
   localparam int ST_IDX_LSB = 8;
   localparam int CT_PEND    = 30;
   localparam int CT_MASK    = 31;
   localparam int REC_VALID  = 31;

   typedef struct packed {
      logic ovf;
      logic pend;
      logic ip;
      logic emit;
   } evt_t;

   // report one fault condition; signal only if nothing was outstanding
   function automatic evt_t raise_evt(evt_t s, logic masked, logic is_ovf);
      evt_t r;
      logic prior;
      r     = s;
      prior = s.ovf | s.pend;
      if (is_ovf) r.ovf  = 1'b1;
      else        r.pend = 1'b1;
      if (!prior) begin
         if (masked) r.ip   = 1'b1;
         else        r.emit = 1'b1;
      end
      return r;
   endfunction

endpackage

// File: rtl/flt_record_bank.sv
module flt_record_bank #(
   parameter int NUM_SLOTS = 1,
   parameter int SLOT_W    = 1,
   parameter int SRC_W     = 16,
   parameter int IDX_W     = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 set_en,
   input  logic [SLOT_W-1:0]    set_slot,
   input  logic [7:0]           set_reason,
   input  logic [SRC_W-1:0]     set_src,
   input  logic [IDX_W-1:0]     set_idx,
   input  logic                 clr_en,
   input  logic [SLOT_W-1:0]    clr_slot,
   input  logic [SLOT_W-1:0]    rd_slot,
   input  logic [1:0]           rd_dw,
   output logic [NUM_SLOTS-1:0] valid_q,
   output logic [31:0]          rd_data
);
   import fault_log_pkg::*;

   logic [31:0] slot_rd [NUM_SLOTS];

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      logic             v_q;
      logic [7:0]       reason_q;
      logic [SRC_W-1:0] src_q;
      logic [IDX_W-1:0] idx_q;
      logic             hit_set, hit_clr;

      assign hit_set = set_en && (set_slot == SLOT_W'(s));
      assign hit_clr = clr_en && (clr_slot == SLOT_W'(s));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q      <= 1'b0;
            reason_q <= '0;
            src_q    <= '0;
            idx_q    <= '0;
         end else if (hit_set) begin
            // a fault lands after a same-cycle free, so setting wins
            v_q      <= 1'b1;
            reason_q <= set_reason;
            src_q    <= set_src;
            idx_q    <= set_idx;
         end else if (hit_clr) begin
            v_q      <= 1'b0;
         end
      end

      assign valid_q[s] = v_q;

      always_comb begin
         unique case (rd_dw)
            2'd0:    slot_rd[s] = 32'h0;
            2'd1:    slot_rd[s] = 32'(idx_q) << 16;
            2'd2:    slot_rd[s] = 32'(src_q);
            default: slot_rd[s] = {v_q, 23'h0, reason_q};
         endcase
      end
   end

   always_comb begin
      rd_data = 32'h0;
      for (int s = 0; s < NUM_SLOTS; s++)
         if (rd_slot == SLOT_W'(s)) rd_data = slot_rd[s];
   end

   // R9: a free request without a same-slot set leaves that slot invalid
   assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !set_en) |=> ((valid_q & (NUM_SLOTS'(1) << $past(clr_slot))) == '0))
      else $error("assert_free_clears_slot_R9");

endmodule

// File: rtl/flt_msg_port.sv
module flt_msg_port (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        fire,
   input  logic [31:0] addr_in,
   input  logic [31:0] data_in,
   input  logic        msg_ready,
   output logic        msg_valid,
   output logic [31:0] msg_addr,
   output logic [31:0] msg_data
);
   logic can_load;
   assign can_load = !msg_valid || msg_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         msg_valid <= 1'b0;
         msg_addr  <= '0;
         msg_data  <= '0;
      end else begin
         if (msg_valid && msg_ready) msg_valid <= 1'b0;
         // a request while a message is still unaccepted merges into it
         if (fire && can_load) begin
            msg_valid <= 1'b1;
            msg_addr  <= addr_in;
            msg_data  <= data_in;
         end
      end
   end

   assert_msg_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

endmodule

// File: rtl/fault_log_ctrl.sv
module fault_log_ctrl #(
   parameter int         NUM_SLOTS = 1,
   parameter int         REG_AW    = 8,
   parameter int         SRC_W     = 16,
   parameter int         IDX_W     = 16,
   parameter logic [7:0] REASON_LO = 8'h20,
   parameter logic [7:0] REASON_HI = 8'h26
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flt_valid,
   input  logic [7:0]        flt_reason,
   input  logic [SRC_W-1:0]  flt_source,
   input  logic [IDX_W-1:0]  flt_index,
   input  logic              reg_wr_en,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              msg_valid,
   output logic [31:0]       msg_addr,
   output logic [31:0]       msg_data,
   input  logic              msg_ready,
   output logic              unsup_err
);
   import fault_log_pkg::*;

   localparam int SLOT_W  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
   localparam int REC_END = OFF_REC_BASE + REC_BYTES * NUM_SLOTS;

   initial begin : param_checks
      assert (NUM_SLOTS >= 1) else $error("NUM_SLOTS must be at least 1");
      assert (SLOT_W <= 8) else $error("slot index must fit the 8-bit index field");
      assert (REC_END <= (1 << REG_AW)) else $error("REG_AW too small for the slots");
      assert (SRC_W >= 1 && SRC_W <= 16) else $error("SRC_W out of range");
      assert (IDX_W >= 1 && IDX_W <= 16) else $error("IDX_W out of range");
      assert (REASON_LO <= REASON_HI) else $error("empty reason range");
   end

   // state
   logic              ovf_q, pend_q, ip_q, mask_q, unsup_q;
   logic [SLOT_W-1:0] ptr_q, last_q;
   logic [31:0]       maddr_q, mdata_q;
   logic [NUM_SLOTS-1:0] valid_q;

   // decode
   logic              aligned, hit_status, hit_ctrl, hit_maddr, hit_mdata, hit_rec;
   logic [REG_AW-1:0] rec_rel;
   logic [SLOT_W-1:0] rec_slot;
   logic [1:0]        rec_dw;
   logic [31:0]       rec_rd;

   assign aligned    = (reg_addr[1:0] == 2'b00);
   assign hit_status = (reg_addr == REG_AW'(OFF_STATUS));
   assign hit_ctrl   = (reg_addr == REG_AW'(OFF_CTRL));
   assign hit_maddr  = (reg_addr == REG_AW'(OFF_MADDR));
   assign hit_mdata  = (reg_addr == REG_AW'(OFF_MDATA));
   assign hit_rec    = aligned && (32'(reg_addr) >= OFF_REC_BASE) && (32'(reg_addr) < REC_END);
   assign rec_rel    = reg_addr - REG_AW'(OFF_REC_BASE);
   assign rec_slot   = SLOT_W'(rec_rel >> 4);
   assign rec_dw     = rec_rel[3:2];

   // next-state, write first then fault
   evt_t                 st1, st2;
   logic                 mask_d, unsup_d, clr_en, set_en, reason_ok, ptr_busy;
   logic [SLOT_W-1:0]    ptr_d, last_d, ptr_nxt;
   logic [31:0]          maddr_d, mdata_d;
   logic [NUM_SLOTS-1:0] valid1;

   assign reason_ok = (flt_reason >= REASON_LO) && (flt_reason <= REASON_HI);
   assign ptr_nxt   = (ptr_q == SLOT_W'(NUM_SLOTS - 1)) ? '0 : ptr_q + 1'b1;

   always_comb begin
      st1.ovf  = ovf_q;
      st1.pend = pend_q;
      st1.ip   = ip_q;
      st1.emit = 1'b0;
      mask_d   = mask_q;
      maddr_d  = maddr_q;
      mdata_d  = mdata_q;
      clr_en   = 1'b0;
      valid1   = valid_q;
      if (reg_wr_en) begin
         if (hit_ctrl) begin
            mask_d = reg_wdata[CT_MASK];
            if (!reg_wdata[CT_MASK] && st1.ip) begin
               st1.ip   = 1'b0;
               st1.emit = 1'b1;
            end
         end
         if (hit_status) begin
            if (reg_wdata[ST_OVF]) st1.ovf = 1'b0;
            if (!st1.ovf && !st1.pend) st1.ip = 1'b0;
         end
         if (hit_maddr) maddr_d = reg_wdata;
         if (hit_mdata) mdata_d = reg_wdata;
         if (hit_rec && rec_dw == 2'd3 && reg_wdata[REC_VALID]) begin
            clr_en = 1'b1;
            for (int s = 0; s < NUM_SLOTS; s++)
               if (rec_slot == SLOT_W'(s)) valid1[s] = 1'b0;
            if (|valid1) st1 = raise_evt(st1, mask_d, 1'b0);
            else begin
               st1.pend = 1'b0;
               if (!st1.ovf) st1.ip = 1'b0;
            end
         end
      end

      st2      = st1;
      set_en   = 1'b0;
      ptr_d    = ptr_q;
      last_d   = last_q;
      unsup_d  = unsup_q;
      ptr_busy = |(valid1 & (NUM_SLOTS'(1) << ptr_q));
      if (flt_valid) begin
         if (!reason_ok) unsup_d = 1'b1;
         else if (!st2.ovf) begin
            if (ptr_busy) st2 = raise_evt(st2, mask_d, 1'b1);
            else begin
               set_en = 1'b1;
               last_d = ptr_q;
               ptr_d  = ptr_nxt;
               st2    = raise_evt(st2, mask_d, 1'b0);
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovf_q   <= 1'b0;
         pend_q  <= 1'b0;
         ip_q    <= 1'b0;
         mask_q  <= 1'b1;
         unsup_q <= 1'b0;
         ptr_q   <= '0;
         last_q  <= '0;
         maddr_q <= '0;
         mdata_q <= '0;
      end else begin
         ovf_q   <= st2.ovf;
         pend_q  <= st2.pend;
         ip_q    <= st2.ip;
         mask_q  <= mask_d;
         unsup_q <= unsup_d;
         ptr_q   <= ptr_d;
         last_q  <= last_d;
         maddr_q <= maddr_d;
         mdata_q <= mdata_d;
      end
   end

   flt_record_bank #(
      .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .SRC_W(SRC_W), .IDX_W(IDX_W)
   ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .set_en(set_en), .set_slot(ptr_q), .set_reason(flt_reason),
      .set_src(flt_source), .set_idx(flt_index),
      .clr_en(clr_en), .clr_slot(rec_slot),
      .rd_slot(rec_slot), .rd_dw(rec_dw),
      .valid_q(valid_q), .rd_data(rec_rd)
   );

   flt_msg_port u_msg (
      .clk(clk), .rst_n(rst_n), .fire(st2.emit),
      .addr_in(maddr_d), .data_in(mdata_d), .msg_ready(msg_ready),
      .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data)
   );

   always_comb begin
      reg_rdata = 32'h0;
      if (hit_status)     reg_rdata = {16'h0, 8'(last_q), 6'h0, pend_q, ovf_q};
      else if (hit_ctrl)  reg_rdata = {mask_q, ip_q, 30'h0};
      else if (hit_maddr) reg_rdata = maddr_q;
      else if (hit_mdata) reg_rdata = mdata_q;
      else if (hit_rec)   reg_rdata = rec_rd;
   end

   assign unsup_err = unsup_q;

   assert_pend_tracks_slots_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q == (|valid_q));
   assert_ip_only_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ip_q |-> mask_q);
   assert_ip_needs_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ip_q |-> (ovf_q || pend_q));
   assert_overflow_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && flt_valid && !reg_wr_en) |=> ($stable(valid_q) && $stable(ptr_q)));
   assert_no_resignal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_valid && !reg_wr_en && (ovf_q || pend_q)) |=> $stable(ip_q));
   assert_unsup_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
      unsup_q |=> unsup_q);

endmodule

// File: tb/fault_log_ctrl_test.sv
module fault_log_ctrl_test;
   localparam int N = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flt_valid = 1'b0;
   logic [7:0]  flt_reason = '0;
   logic [15:0] flt_source = '0, flt_index = '0;
   logic        reg_wr_en = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        msg_valid, msg_ready = 1'b0;
   logic [31:0] msg_addr, msg_data;
   logic        unsup_err;

   always #5 clk = ~clk;

   fault_log_ctrl #(.NUM_SLOTS(N), .REG_AW(8)) uut (
      .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_reason(flt_reason),
      .flt_source(flt_source), .flt_index(flt_index), .reg_wr_en(reg_wr_en),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data),
      .msg_ready(msg_ready), .unsup_err(unsup_err)
   );

   int checks = 0, errors = 0;
   int obs_msgs = 0;
   logic count_on = 1'b0;

   always @(negedge clk) if (count_on && msg_valid && msg_ready) obs_msgs++;

   // bench model (from the requirements)
   logic [N-1:0] m_v;
   logic [7:0]   m_rs [N];
   int           m_ptr, m_last, m_emits;
   logic         m_ovf, m_ip, m_mask;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   task automatic chk_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(req, v, exp);
   endtask

   task automatic cyc(input logic w, input logic [7:0] a, input logic [31:0] d,
                      input logic f, input logic [7:0] r, input logic [15:0] s,
                      input logic [15:0] ix);
      reg_wr_en = w; reg_addr = a; reg_wdata = d;
      flt_valid = f; flt_reason = r; flt_source = s; flt_index = ix;
      @(posedge clk);
      @(negedge clk);
      reg_wr_en = 1'b0; flt_valid = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      cyc(1'b1, a, d, 1'b0, 8'h0, 16'h0, 16'h0);
   endtask

   task automatic flt(input logic [7:0] r, input logic [15:0] s, input logic [15:0] ix);
      cyc(1'b0, 8'h0, 32'h0, 1'b1, r, s, ix);
   endtask

   function automatic logic [7:0] slot_top(input int s);
      return 8'(16 + 16 * s + 12);
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_v = '0; m_ptr = 0; m_last = 0; m_emits = 0;
      m_ovf = 1'b0; m_ip = 1'b0; m_mask = 1'b1;
      for (int s = 0; s < N; s++) m_rs[s] = 8'h0;
   endtask

   task automatic m_raise(input logic is_ovf);
      logic prior;
      prior = m_ovf | (|m_v);
      if (!prior) begin
         if (m_mask) m_ip = 1'b1;
         else m_emits++;
      end
      if (is_ovf) m_ovf = 1'b1;
   endtask

   // model of one cycle: register write first, then fault (R11)
   task automatic m_step(input logic w, input logic [7:0] a, input logic [31:0] d,
                         input logic f, input logic [7:0] r);
      if (w) begin
         if (a == 8'h04) begin
            if (!d[31] && m_ip) begin m_ip = 1'b0; m_emits++; end
            m_mask = d[31];
         end
         if (a == 8'h00) begin
            if (d[0]) m_ovf = 1'b0;
            if (!m_ovf && !(|m_v)) m_ip = 1'b0;
         end
         if (a >= 8'h10 && a[3:0] == 4'hC && d[31]) begin
            m_v[(a - 8'h10) >> 4] = 1'b0;
            if (!(|m_v) && !m_ovf) m_ip = 1'b0;
         end
      end
      if (f && r >= 8'h20 && r <= 8'h26 && !m_ovf) begin
         if (m_v[m_ptr]) m_raise(1'b1);
         else begin
            m_raise(1'b0);
            m_v[m_ptr] = 1'b1;
            m_rs[m_ptr] = r;
            m_last = m_ptr;
            m_ptr = (m_ptr + 1) % N;
         end
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [31:0] st0, v;
      void'($urandom(32'd20240611));
      @(negedge clk);
      do_reset();

      // R1 reset state
      chk_rd("R1 status", 8'h00, 32'h0);
      chk_rd("R1 ctrl", 8'h04, 32'h8000_0000);
      chk_rd("R1 maddr", 8'h08, 32'h0);
      chk_rd("R1 slot0 dw3", slot_top(0), 32'h0);
      chk("R1 msg_valid", {31'h0, msg_valid}, 32'h0);
      chk("R1 unsup_err", {31'h0, unsup_err}, 32'h0);

      wr(8'h08, 32'hFEE0_1000);
      wr(8'h0C, 32'h0000_0041);
      wr(8'h04, 32'h4000_0000);           // unmask, try to write pending
      chk_rd("R7 pending not writable", 8'h04, 32'h0);
      chk("R7 no message", {31'h0, msg_valid}, 32'h0);

      // first fault: recorded and signalled
      flt(8'h22, 16'hABCD, 16'h1234);
      chk("R10 msg_valid next cycle", {31'h0, msg_valid}, 32'h1);
      chk("R10 msg_addr", msg_addr, 32'hFEE0_1000);
      chk("R5 msg_data", msg_data, 32'h0000_0041);
      chk_rd("R5 pending stays 0", 8'h04, 32'h0);
      chk_rd("R3 status", 8'h00, 32'h0000_0002);
      chk_rd("R2 dw3", slot_top(0), 32'h8000_0022);
      chk_rd("R2 dw2", 8'h18, 32'h0000_ABCD);
      chk_rd("R2 dw1", 8'h14, 32'h1234_0000);
      chk_rd("R2 dw0", 8'h10, 32'h0);
      repeat (2) @(negedge clk);
      chk("R10 held", {31'h0, msg_valid}, 32'h1);
      chk("R10 held addr", msg_addr, 32'hFEE0_1000);
      msg_ready = 1'b1;
      @(negedge clk);
      msg_ready = 1'b0;
      chk("R10 drop after accept", {31'h0, msg_valid}, 32'h0);

      // R6 second fault, primary pending already set
      flt(8'h23, 16'h0002, 16'h0003);
      chk("R6 no message", {31'h0, msg_valid}, 32'h0);
      chk_rd("R2 pointer advance", 8'h00, 32'h0000_0102);
      flt(8'h24, 16'h0003, 16'h0004);
      flt(8'h25, 16'h0004, 16'h0005);
      chk_rd("R2 slot3", 8'h00, 32'h0000_0302);
      flt(8'h26, 16'h0009, 16'h0009);     // slot 0 still valid
      chk_rd("R4 overflow", 8'h00, 32'h0000_0303);
      chk_rd("R4 slot0 kept", 8'h18, 32'h0000_ABCD);
      chk("R6 no message on overflow", {31'h0, msg_valid}, 32'h0);
      flt(8'h20, 16'h0077, 16'h0077);
      chk_rd("R4 dropped status", 8'h00, 32'h0000_0303);
      chk_rd("R4 dropped slot0", 8'h18, 32'h0000_ABCD);

      wr(8'h00, 32'h0000_0002);
      chk_rd("R3 not cleared by write", 8'h00, 32'h0000_0303);
      wr(8'h00, 32'h0000_0001);
      chk_rd("R8 overflow cleared", 8'h00, 32'h0000_0302);

      // R11 free slot0 and fault in the same cycle
      cyc(1'b1, slot_top(0), 32'h8000_0000, 1'b1, 8'h21, 16'h0005, 16'h0006);
      chk_rd("R11 recorded in freed slot", slot_top(0), 32'h8000_0021);
      chk_rd("R11 source", 8'h18, 32'h0000_0005);
      chk_rd("R11 no overflow", 8'h00, 32'h0000_0002);
      chk("R11 no message", {31'h0, msg_valid}, 32'h0);

      for (int s = 0; s < N; s++) wr(slot_top(s), 32'h8000_0000);
      chk_rd("R9 all freed", 8'h00, 32'h0);

      // R5 masked report, R7 replay on unmask
      wr(8'h04, 32'h8000_0000);
      flt(8'h23, 16'h0010, 16'h0011);     // slot 1
      chk_rd("R5 pending set", 8'h04, 32'hC000_0000);
      chk("R5 masked no message", {31'h0, msg_valid}, 32'h0);
      wr(8'h04, 32'h0000_0000);
      chk("R7 replay message", {31'h0, msg_valid}, 32'h1);
      chk_rd("R7 pending cleared", 8'h04, 32'h0);
      msg_ready = 1'b1;
      @(negedge clk);
      msg_ready = 1'b0;

      // R8 / R9 pending clearing
      wr(8'h04, 32'h8000_0000);
      wr(slot_top(1), 32'h8000_0000);
      flt(8'h24, 16'h0020, 16'h0021);     // slot 2
      chk_rd("R5 pending again", 8'h04, 32'hC000_0000);
      wr(8'h00, 32'h0000_0001);
      chk_rd("R8 pending kept by primary", 8'h04, 32'hC000_0000);
      wr(slot_top(2), 32'h8000_0000);
      chk_rd("R9 pending cleared", 8'h04, 32'h8000_0000);
      flt(8'h20, 16'h1, 16'h1);           // slot 3, pending set
      flt(8'h20, 16'h2, 16'h2);           // slot 0
      flt(8'h20, 16'h3, 16'h3);           // slot 1
      flt(8'h20, 16'h4, 16'h4);           // slot 2
      flt(8'h20, 16'h5, 16'h5);           // slot 3 busy: overflow
      chk_rd("R4 overflow second", 8'h00, 32'h0000_0203);
      for (int s = 0; s < N; s++) wr(slot_top(s), 32'h8000_0000);
      chk_rd("R9 overflow keeps pending", 8'h04, 32'hC000_0000);
      chk_rd("R9 status overflow only", 8'h00, 32'h0000_0201);
      wr(8'h00, 32'h0000_0001);
      chk_rd("R8 status clear", 8'h00, 32'h0000_0200);
      chk_rd("R8 pending cleared", 8'h04, 32'h8000_0000);
      chk("R5 masked stays silent", {31'h0, msg_valid}, 32'h0);

      // R12 unsupported reasons
      rd(8'h00, st0);
      flt(8'h05, 16'h00AA, 16'h00BB);
      chk("R12 unsup set", {31'h0, unsup_err}, 32'h1);
      chk_rd("R12 status unchanged", 8'h00, st0);
      flt(8'h27, 16'h00AA, 16'h00BB);
      repeat (3) @(negedge clk);
      chk("R12 unsup sticky", {31'h0, unsup_err}, 32'h1);
      chk_rd("R12 slot3 not written", slot_top(3), 32'h0000_0020);

      // random phase
      do_reset();
      wr(8'h08, 32'hFEE0_2000);
      wr(8'h0C, 32'h0000_0055);
      msg_ready = 1'b1;
      count_on = 1'b1;
      for (int i = 0; i < 400; i++) begin
         int op;
         logic w, f;
         logic [7:0] a, r;
         logic [31:0] d;
         op = int'($urandom_range(0, 9));
         w = 1'b0; f = 1'b0; a = 8'h0; d = 32'h0;
         r = 8'h20 + 8'($urandom_range(0, 6));
         case (op)
            0, 1, 2, 3: f = 1'b1;
            4: begin w = 1'b1; a = slot_top(int'($urandom_range(0, N - 1))); d = 32'h8000_0000; end
            5: begin w = 1'b1; a = 8'h00; d = 32'($urandom_range(0, 3)); end
            6: begin w = 1'b1; a = 8'h04; d = {1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 30'h0}; end
            7: begin w = 1'b1; f = 1'b1; a = slot_top(int'($urandom_range(0, N - 1))); d = 32'h8000_0000; end
            default: ;
         endcase
         cyc(w, a, d, f, r, 16'($urandom), 16'($urandom));
         m_step(w, a, d, f, r);
         chk_rd("R3 R4 random status", 8'h00, {16'h0, 8'(m_last), 6'h0, |m_v, m_ovf});
         chk_rd("R5 R7 random ctrl", 8'h04, {m_mask, m_ip, 30'h0});
      end
      repeat (2) @(negedge clk);
      count_on = 1'b0;
      chk("R10 random message count", 32'(obs_msgs), 32'(m_emits));
      for (int s = 0; s < N; s++) begin
         rd(slot_top(s), v);
         chk("R2 R9 random slot", v, {m_v[s], 23'h0, m_rs[s]});
      end
      chk("R12 cleared by reset", {31'h0, unsup_err}, 32'h0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule